// File: doc/BRIEF.md
# Coarse-Compensated Seconds Prescaler

This block turns a 32.768 kHz crystal-domain clock into a seconds tick. It counts crystal cycles up to a terminal value and issues a one-cycle pulse each time the count wraps. It also drives a 1 Hz square wave that an external frequency counter can measure. A crystal whose frequency is slightly off is corrected in whole-cycle steps. Software supplies a 16-bit compensation word. The word names a signed cycle adjustment and an interval length in seconds. The whole adjustment lands on the last second of each interval, so that one second is longer or shorter than the rest.

A loaded word does not disturb the second in progress. It is held as pending and takes over at the next seconds boundary, where a fresh interval starts from zero. With compensation off, every second lasts exactly the nominal cycle count. Compensation is off after reset, when the interval field is 0, and when the adjustment field is 0.

The core is a three-state controller. `ST_PLAIN` means compensation is off and every second is nominal. `ST_COUNT` means the current second is a plain second inside an active interval. `ST_ADJUST` means the current second is the last one of the interval and its terminal count carries the adjustment.

Every transition happens on the cycle the counter reaches its terminal value:
- load-apply: a pending or same-cycle word is taken. The next state is `ST_PLAIN` if the word disables compensation, `ST_ADJUST` for an interval of 1, and `ST_COUNT` otherwise.
- count-advance: `ST_COUNT` stays in `ST_COUNT` until the second before last, then moves to `ST_ADJUST`.
- interval-wrap: `ST_ADJUST` returns to `ST_COUNT`, or stays in `ST_ADJUST` when the interval is 1.
- plain-hold: `ST_PLAIN` stays in `ST_PLAIN`.

Top module: `rtc_coarse_comp`

## Requirements
- R1: During and directly after reset `sec_tick` is low, `clk_1hz` is high, and compensation is off.
- R2: While compensation is off, consecutive `sec_tick` pulses are `CYC_PER_SEC` cycles apart. Compensation is off after reset, for an interval field of 0, and for an adjustment field of 0.
- R3: `sec_tick` is high for exactly one cycle per second. It is high in the first cycle of each new second.
- R4: In the compensation word, bits [7:0] are a signed two's-complement adjustment A and bits [15:8] are an interval N in seconds. With N ≥ 1 and A ≠ 0, each interval has N-1 seconds of `CYC_PER_SEC` cycles, followed by one second of `CYC_PER_SEC - A` cycles. Its terminal count is `CYC_PER_SEC - 1 - A`.
- R5: A negative adjustment lengthens the corrected second: 0xF9 (-7) adds 7 cycles. A positive adjustment shortens it.
- R6: With N = 1 every second carries the adjustment.
- R7: A word loaded in the middle of a second leaves that second at the length set by the previous word. The new word governs from the next boundary onward.
- R8: Each load restarts the interval from second zero. Reloading the same word partway through an interval therefore postpones the corrected second.
- R9: `clk_1hz` rises in the same cycle as `sec_tick` and stays high for `CYC_PER_SEC/2` cycles of each second. This holds for any second at least that long.
- R10: The adjustment range reaches both ends of the field. A = -128 gives a second of `CYC_PER_SEC + 128` cycles, and A = 127 gives `CYC_PER_SEC - 127` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comp_word | input | 16 | Compensation word: [15:8] interval, [7:0] signed adjustment |
| comp_load | input | 1 | One-cycle strobe that captures `comp_word` |
| sec_tick | output | 1 | One-cycle pulse at the start of every second |
| clk_1hz | output | 1 | Square wave, high for the first half of each second |

## Verification
The hardest case to reach from the ports is a word change that overlaps a corrected second. The old adjustment must still finish that second, and the new interval must then start cleanly from zero. The stimulus first runs with an interval of 1, so that every second, including the one in progress, is known to be corrected. It then loads a new word ten cycles after a tick, and the scoreboard expects the old corrected length for that second, followed by the new pattern. A second case reloads the same word one second into an interval, which separates a restarted interval count from a free-running one.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int ADJ_W  = 8;
    localparam int SPAN_W = 8;
    localparam int WORD_W = ADJ_W + SPAN_W;

    typedef enum logic [1:0] {
        ST_PLAIN  = 2'd0,
        ST_COUNT  = 2'd1,
        ST_ADJUST = 2'd2
    } rcc_state_e;

    typedef struct packed {
        logic [SPAN_W-1:0]        span;
        logic signed [ADJ_W-1:0]  adj;
    } rcc_word_t;

    function automatic logic word_active(input rcc_word_t w);
        return (w.span != '0) && (w.adj != '0);
    endfunction

    function automatic rcc_state_e entry_state(input rcc_word_t w);
        if (!word_active(w))
            return ST_PLAIN;
        else if (w.span == SPAN_W'(1))
            return ST_ADJUST;
        else
            return ST_COUNT;
    endfunction

endpackage

// File: rtl/rcc_cycle_counter.sv
module rcc_cycle_counter #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] term,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_next,
    output logic          at_term
);

    assign at_term  = (cnt >= term);
    assign cnt_next = at_term ? '0 : cnt + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_next;
    end

endmodule

// File: rtl/rcc_interval_fsm.sv
module rcc_interval_fsm
    import rcc_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768,
    parameter int CW          = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_term,
    input  logic              comp_load,
    input  logic [WORD_W-1:0] comp_word,
    output logic [CW-1:0]     term,
    output rcc_state_e        state,
    output logic [SPAN_W-1:0] sec_idx,
    output logic [SPAN_W-1:0] span_act
);

    localparam logic [CW-1:0] NOM_LAST = CW'(CYC_PER_SEC - 1);

    rcc_state_e        state_q, state_n;
    rcc_word_t         act_q, act_n;
    rcc_word_t         pend_q, pend_n;
    logic              pend_v_q, pend_v_n;
    logic [SPAN_W-1:0] idx_q, idx_n;
    rcc_word_t         incoming;
    logic              take_word;
    logic [CW-1:0]     adj_ext;

    assign incoming  = comp_load ? rcc_word_t'(comp_word) : pend_q;
    assign take_word = comp_load | pend_v_q;

    // next-state logic
    always_comb begin
        state_n  = state_q;
        act_n    = act_q;
        pend_n   = pend_q;
        pend_v_n = pend_v_q;
        idx_n    = idx_q;
        if (at_term) begin
            if (take_word) begin
                act_n    = incoming;
                pend_v_n = 1'b0;
                idx_n    = '0;
                state_n  = entry_state(incoming);
            end else begin
                unique case (state_q)
                    ST_PLAIN: begin
                        state_n = ST_PLAIN;
                    end
                    ST_COUNT: begin
                        idx_n = idx_q + SPAN_W'(1);
                        if (idx_q + SPAN_W'(1) == act_q.span - SPAN_W'(1))
                            state_n = ST_ADJUST;
                    end
                    ST_ADJUST: begin
                        idx_n   = '0;
                        state_n = (act_q.span == SPAN_W'(1)) ? ST_ADJUST : ST_COUNT;
                    end
                    default: begin
                        state_n = ST_PLAIN;
                    end
                endcase
            end
        end else if (comp_load) begin
            pend_n   = rcc_word_t'(comp_word);
            pend_v_n = 1'b1;
            idx_n    = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_PLAIN;
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            state_q  <= state_n;
            act_q    <= act_n;
            pend_q   <= pend_n;
            pend_v_q <= pend_v_n;
            idx_q    <= idx_n;
        end
    end

    // outputs
    assign adj_ext = {{(CW-ADJ_W){act_q.adj[ADJ_W-1]}}, act_q.adj};

    always_comb begin
        unique case (state_q)
            ST_ADJUST: term = NOM_LAST - adj_ext;
            ST_COUNT:  term = NOM_LAST;
            ST_PLAIN:  term = NOM_LAST;
            default:   term = NOM_LAST;
        endcase
    end

    assign state    = state_q;
    assign sec_idx  = idx_q;
    assign span_act = act_q.span;

endmodule

// File: rtl/rcc_tick_out.sv
module rcc_tick_out #(
    parameter int CYC_PER_SEC = 32768,
    parameter int CW          = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_term,
    input  logic [CW-1:0] cnt_next,
    output logic          sec_tick,
    output logic          clk_1hz
);

    localparam logic [CW-1:0] HALF = CW'(CYC_PER_SEC / 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_tick <= 1'b0;
            clk_1hz  <= 1'b1;
        end else begin
            sec_tick <= at_term;
            clk_1hz  <= (cnt_next < HALF);
        end
    end

endmodule

// File: rtl/rtc_coarse_comp.sv
module rtc_coarse_comp
    import rcc_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768
) (
    input  logic        clk_xtal,
    input  logic        rst_n,
    input  logic [15:0] comp_word,
    input  logic        comp_load,
    output logic        sec_tick,
    output logic        clk_1hz
);

    localparam int CW = $clog2(CYC_PER_SEC + (1 << (ADJ_W-1)) + 1) + 1;

    logic [CW-1:0]     term;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_next;
    logic              at_term;
    rcc_state_e        state;
    logic [SPAN_W-1:0] sec_idx;
    logic [SPAN_W-1:0] span_act;

    rcc_cycle_counter #(.CW(CW)) u_cnt (
        .clk      (clk_xtal),
        .rst_n    (rst_n),
        .term     (term),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .at_term  (at_term)
    );

    rcc_interval_fsm #(.CYC_PER_SEC(CYC_PER_SEC), .CW(CW)) u_fsm (
        .clk       (clk_xtal),
        .rst_n     (rst_n),
        .at_term   (at_term),
        .comp_load (comp_load),
        .comp_word (comp_word),
        .term      (term),
        .state     (state),
        .sec_idx   (sec_idx),
        .span_act  (span_act)
    );

    rcc_tick_out #(.CYC_PER_SEC(CYC_PER_SEC), .CW(CW)) u_out (
        .clk      (clk_xtal),
        .rst_n    (rst_n),
        .at_term  (at_term),
        .cnt_next (cnt_next),
        .sec_tick (sec_tick),
        .clk_1hz  (clk_1hz)
    );

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
    import rcc_pkg::*;
#(
    parameter int CW = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     cnt,
    input logic [CW-1:0]     term,
    input logic              at_term,
    input logic              sec_tick,
    input logic              clk_1hz,
    input rcc_state_e        state,
    input logic [SPAN_W-1:0] sec_idx,
    input logic [SPAN_W-1:0] span_act
);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term);  // R4

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);  // R3

    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (cnt == '0));  // R3

    AST_CLK_RISE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_1hz) |-> sec_tick);  // R9

    AST_TERM_HELD_IN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        !at_term |=> $stable(term));  // R7

    AST_IDX_BELOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (sec_idx < span_act));  // R8

endmodule

bind rtc_coarse_comp rcc_checker #(.CW(CW)) u_rcc_chk (
    .clk      (clk_xtal),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .term     (term),
    .at_term  (at_term),
    .sec_tick (sec_tick),
    .clk_1hz  (clk_1hz),
    .state    (state),
    .sec_idx  (sec_idx),
    .span_act (span_act)
);

// File: tb/rtc_coarse_comp_test.sv
module rtc_coarse_comp_test;

    localparam int NOM  = 256;
    localparam int HALF = NOM / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] comp_word = '0;
    logic        comp_load = 1'b0;
    logic        sec_tick;
    logic        clk_1hz;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_coarse_comp #(.CYC_PER_SEC(NOM)) uut (
        .clk_xtal  (clk),
        .rst_n     (rst_n),
        .comp_word (comp_word),
        .comp_load (comp_load),
        .sec_tick  (sec_tick),
        .clk_1hz   (clk_1hz)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input int len, input string tag);
        exp_q.push_back(len);
        tag_q.push_back(tag);
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!sec_tick) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w);
        comp_word = w;
        comp_load = 1'b1;
        @(negedge clk);
        comp_load = 1'b0;
    endtask

    task automatic start_scen(input logic [15:0] w);
        wait (exp_q.size() == 0);
        wait_tick();
        repeat (10) @(negedge clk);
        load(w);
    endtask

    // monitor: measure second lengths and clock-out high time
    initial begin
        int since = 0;
        int hi = 0;
        bit prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev = 1'b0;
            end else if (sec_tick) begin
                if (prev) begin
                    if (since >= HALF)
                        chk(hi == HALF, "R9 clk_1hz high time", hi, HALF);
                    if (exp_q.size() > 0) begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (e >= 0)
                            chk(since == e, t, since, e);
                    end
                end
                chk(clk_1hz == 1'b1, "R9 clk_1hz high at tick", clk_1hz, 1);
                prev  = 1'b1;
                since = 1;
                hi    = clk_1hz ? 1 : 0;
            end else begin
                since++;
                hi += clk_1hz ? 1 : 0;
                if (since > 2 * NOM) prev = 1'b0;
            end
        end
    end

    // driver
    initial begin
        repeat (3) @(negedge clk);
        chk(sec_tick == 1'b0, "R1 sec_tick in reset", sec_tick, 0);
        chk(clk_1hz == 1'b1, "R1 clk_1hz in reset", clk_1hz, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sec_tick == 1'b0, "R1 sec_tick after reset", sec_tick, 0);
        chk(clk_1hz == 1'b1, "R1 clk_1hz after reset", clk_1hz, 1);
        for (int i = 0; i < 3; i++) push(NOM, "R1 R2 reset-default second");

        // R4 R5: -7 over 6 seconds lengthens the last one
        start_scen(16'h06F9);
        push(-1, "");
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 5; i++) push(NOM, "R4 plain second in interval");
            push(NOM + 7, "R5 R4 second lengthened by -7");
        end

        // R5: +5 over 3 seconds shortens the last one
        start_scen(16'h0305);
        push(-1, "");
        for (int k = 0; k < 2; k++) begin
            push(NOM, "R4 plain second");
            push(NOM, "R4 plain second");
            push(NOM - 5, "R5 second shortened by +5");
        end

        // R6: interval 1
        start_scen(16'h0103);
        push(-1, "");
        for (int i = 0; i < 3; i++) push(NOM - 3, "R6 every second adjusted");

        // R7: change word while a corrected second runs
        start_scen(16'h02EC);
        push(NOM - 3, "R7 second in progress keeps old word");
        for (int k = 0; k < 2; k++) begin
            push(NOM, "R7 new interval plain second");
            push(NOM + 20, "R7 new interval corrected second");
        end

        // R8: reload mid-interval restarts count
        start_scen(16'h030A);
        push(-1, "");
        push(NOM, "R8 first second before reload");
        push(NOM, "R8 restarted interval second 0");
        push(NOM, "R8 restarted interval second 1");
        push(NOM - 10, "R8 corrected second after restart");
        wait_tick();
        repeat (10) @(negedge clk);
        load(16'h030A);

        // R2: interval 0 disables
        start_scen(16'h0032);
        push(-1, "");
        for (int i = 0; i < 3; i++) push(NOM, "R2 interval 0 gives nominal");

        // R2: adjustment 0 disables
        start_scen(16'h0400);
        push(-1, "");
        for (int i = 0; i < 5; i++) push(NOM, "R2 adjustment 0 gives nominal");

        // R10: field extremes
        start_scen(16'h0280);
        push(-1, "");
        for (int k = 0; k < 2; k++) begin
            push(NOM, "R10 plain second");
            push(NOM + 128, "R10 adjustment -128");
        end
        start_scen(16'h027F);
        push(-1, "");
        for (int k = 0; k < 2; k++) begin
            push(NOM, "R10 plain second");
            push(NOM - 127, "R10 adjustment 127");
        end

        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    // watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule